// File: doc/BRIEF.md
# Multiplexed Serial Receive Engine

This block receives characters on sixteen asynchronous serial input lines, none of which has a receiver of its own. A single scan sequencer visits the lines in turn. Every line is sampled once per scan, and a scan is started by a pulse that arrives at eight times the bit rate. All per-line receive state is held outside the block, in a shared word-addressed memory. For each line on each scan, the engine reads that line's assembly word, advances the sampling state by one sample and writes the word back.

When a line delivers its stop bit, the engine looks at the next slot of a 64-entry circular input queue that also lives in that memory. If the slot is free, the engine stores a tagged entry there: the character, a break flag, a parity bit and the line number. The engine then pulses the receive interrupt, provided interrupts are enabled. Software drains the queue by clearing the valid bit of each entry it consumes.

The memory is reached through a request/grant port. A host bus decoder drives the configuration inputs: table base, character length, receiver enable, interrupt enable and overrun clear.

Top module: `mux_rx_engine`

## Requirements
- R1: After reset, memReq, rxIrq and overrunFlag are low, and the queue write pointer points at slot 0.
- R2: The engine holds memReq, memWe, memAddr and memWdata unchanged until memGnt is high in the same cycle. Read data is taken from memRdata in the cycle after the grant. Every address carries tableBase in bits 14..7.
- R3: The assembly word of line n is at word offset 0x20+n from the base. Its layout is: state in bits 15..12, sample phase in bits 11..9, bit 8 zero, data in bits 7..0. The state codes are 0 armed, 1 waiting for mark, 2 start, 3+k data bit k, and 11 stop. The engine rewrites the word on every sample of that line.
- R4: An armed line that samples space starts a character. The start bit is confirmed at the 4th following sample. Data bits are then taken every 8 samples, least significant bit first, and the stop bit 8 samples after the last data bit.
- R5: charLen codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The character is stored right-justified, and the unused upper bits are zero.
- R6: A queue entry has valid in bit 15, break in bit 14, parity in bit 13, line number in bits 12..9, zero in bit 8 and the character in bits 7..0. Parity is the XOR of the received data bits.
- R7: The entry goes to word offset 0x40+ptr. The pointer advances by one per stored entry and wraps modulo 64. Lines that complete on the same scan are stored in ascending line order.
- R8: A line that stays at space through the stop sample with all-zero data produces a single entry with break set, parity 0 and character 0. The line then produces no further entry until it has returned to mark.
- R9: If the target slot still has its valid bit set, the engine writes nothing and leaves the pointer unchanged. In that case it sets overrunFlag, which stays set until ovrClr.
- R10: rxIrq is a one-cycle pulse that follows each stored entry, and it occurs only while recvIntEnable is set.
- R11: While recvEnable is low, the engine ignores sampleTick and makes no memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxLines | input | 16 | Serial inputs, 1 = mark |
| sampleTick | input | 1 | Starts one scan of all lines (8x bit rate) |
| recvEnable | input | 1 | Receiver enable |
| recvIntEnable | input | 1 | Receive interrupt enable |
| charLen | input | 2 | Data bits minus 5 |
| tableBase | input | 8 | Upper address bits of the tables |
| ovrClr | input | 1 | Clears the overrun flag |
| memGnt | input | 1 | Memory grant |
| memRdata | input | 16 | Read data, cycle after grant |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Write request when high |
| memAddr | output | 15 | Word address |
| memWdata | output | 16 | Write data |
| rxIrq | output | 1 | Receive interrupt pulse |
| overrunFlag | output | 1 | Sticky queue overrun |

## Verification
Several properties are checked on every cycle. The memory request must stay stable while it waits for a grant, and every address must be aligned to the base. Every queue write must carry the valid tag and a zero spare bit. The pointer may only step by one, the overrun flag must stay set, and interrupts may only follow a granted write while enabled. Other behaviour can only be shown by the bench scenarios. These cover the bit timing of start, data and stop samples, right-justification for each character length, parity and line tags, ordering within one scan, break detection with a single entry, pointer wrap, and refusal to overwrite an occupied slot.

// File: rtl/mux_rx_pkg.sv
package mux_rx_pkg;
  localparam int NUM_LINES = 16;
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int FIFO_SLOTS = 64;
  localparam int PTR_W = $clog2(FIFO_SLOTS);
  localparam int OSR = 8;
  localparam int PH_W = $clog2(OSR);
  localparam int BASE_W = 8;
  localparam int ADDR_W = BASE_W + 7;
  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;

  localparam logic [3:0] ST_ARMED = 4'd0;
  localparam logic [3:0] ST_HOLD  = 4'd1;
  localparam logic [3:0] ST_START = 4'd2;
  localparam logic [3:0] ST_DATA0 = 4'd3;
  localparam logic [3:0] ST_STOP  = 4'd11;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ASM, S_GET_ASM, S_WR_ASM,
    S_RD_SLOT, S_GET_SLOT, S_WR_SLOT, S_NEXT
  } seqState_e;

  typedef struct packed {
    logic startScan;
    logic nextLine;
    logic loadAsm;
    logic bumpPtr;
    logic flagOvr;
    logic pickSlot;
  } ctrlStrobe_t;
endpackage

// File: rtl/mux_rx_datapath.sv
module mux_rx_datapath
  import mux_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rxLines,
  input  logic [BASE_W-1:0]    tableBase,
  input  logic [1:0]           charLen,
  input  logic                 ovrClr,
  input  logic [WORD_W-1:0]    memRdata,
  input  ctrlStrobe_t          strobe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    memWdata,
  output logic                 charDone,
  output logic                 lastLine,
  output logic                 overrunFlag
);
  localparam logic [PH_W-1:0] MID_PHASE = PH_W'(OSR / 2);

  logic [LINE_W-1:0]    lineIdx;
  logic [NUM_LINES-1:0] snap;
  logic [WORD_W-1:0]    asmWord;
  logic [PTR_W-1:0]     wrPtr;
  logic                 ovrFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineIdx <= '0;
      snap    <= '1;
      asmWord <= '0;
      wrPtr   <= '0;
      ovrFlag <= 1'b0;
    end else begin
      if (strobe.startScan) begin
        lineIdx <= '0;
        snap    <= rxLines;
      end else if (strobe.nextLine) begin
        lineIdx <= lineIdx + 1'b1;
      end
      if (strobe.loadAsm) asmWord <= memRdata;
      if (strobe.bumpPtr) wrPtr <= wrPtr + 1'b1;
      if (strobe.flagOvr) ovrFlag <= 1'b1;
      else if (ovrClr)    ovrFlag <= 1'b0;
    end
  end

  // sample-step evaluation of the fetched assembly word
  logic [3:0]        stCur, stNew, lastData;
  logic [PH_W-1:0]   phCur, phInc, phNew;
  logic [CHAR_W-1:0] datCur, datNew;
  logic [2:0]        dIdx;
  logic              bitIn, isBreak, corrupt;

  assign stCur    = asmWord[15:12];
  assign phCur    = asmWord[11:9];
  assign datCur   = asmWord[7:0];
  assign corrupt  = asmWord[8];
  assign bitIn    = snap[lineIdx];
  assign phInc    = phCur + 1'b1;
  assign lastData = ST_DATA0 + 4'd4 + {2'b00, charLen};
  assign dIdx     = 3'(stCur - ST_DATA0);

  always_comb begin
    stNew    = stCur;
    phNew    = phCur;
    datNew   = datCur;
    charDone = 1'b0;
    isBreak  = 1'b0;
    if (corrupt) begin
      stNew = ST_ARMED;
      phNew = '0;
      datNew = '0;
    end else begin
      case (stCur)
        ST_ARMED: if (!bitIn) begin
          stNew = ST_START;
          phNew = '0;
        end
        ST_HOLD: if (bitIn) stNew = ST_ARMED;
        ST_START: begin
          phNew = phInc;
          if (phInc == MID_PHASE) begin
            phNew  = '0;
            datNew = '0;
            stNew  = bitIn ? ST_ARMED : ST_DATA0;
          end
        end
        ST_STOP: begin
          phNew = phInc;
          if (phInc == '0) begin
            charDone = 1'b1;
            isBreak  = !bitIn && (datCur == '0);
            stNew    = bitIn ? ST_ARMED : ST_HOLD;
          end
        end
        default: begin
          if (stCur > ST_STOP) begin
            stNew = ST_ARMED;
            phNew = '0;
          end else begin
            phNew = phInc;
            if (phInc == '0) begin
              datNew[dIdx] = bitIn;
              stNew = (stCur == lastData) ? ST_STOP : stCur + 1'b1;
            end
          end
        end
      endcase
    end
  end

  logic [WORD_W-1:0] entryWord, asmNew;
  assign asmNew    = {stNew, phNew, 1'b0, datNew};
  assign entryWord = {1'b1, isBreak, isBreak ? 1'b0 : ^datCur, lineIdx, 1'b0,
                      isBreak ? {CHAR_W{1'b0}} : datCur};

  assign memAddr     = strobe.pickSlot ? {tableBase, 1'b1, wrPtr}
                                       : {tableBase, 2'b01, 1'b0, lineIdx};
  assign memWdata    = strobe.pickSlot ? entryWord : asmNew;
  assign lastLine    = (lineIdx == LINE_W'(NUM_LINES - 1));
  assign overrunFlag = ovrFlag;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrPtr) |-> wrPtr == PTR_W'($past(wrPtr) + 1'b1)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !ovrClr |=> ovrFlag); // R9
endmodule

// File: rtl/mux_rx_ctrl.sv
module mux_rx_ctrl
  import mux_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        recvEnable,
  input  logic        recvIntEnable,
  input  logic        memGnt,
  input  logic        charDone,
  input  logic        lastLine,
  input  logic        slotTaken,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        rxIrq
);
  seqState_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: if (sampleTick && recvEnable) begin
        strobe.startScan = 1'b1;
        nextState = S_RD_ASM;
      end
      S_RD_ASM:  if (memGnt) nextState = S_GET_ASM;
      S_GET_ASM: begin
        strobe.loadAsm = 1'b1;
        nextState = S_WR_ASM;
      end
      S_WR_ASM:  if (memGnt) nextState = charDone ? S_RD_SLOT : S_NEXT;
      S_RD_SLOT: begin
        strobe.pickSlot = 1'b1;
        if (memGnt) nextState = S_GET_SLOT;
      end
      S_GET_SLOT: begin
        strobe.pickSlot = 1'b1;
        if (slotTaken) begin
          strobe.flagOvr = 1'b1;
          nextState = S_NEXT;
        end else begin
          nextState = S_WR_SLOT;
        end
      end
      S_WR_SLOT: begin
        strobe.pickSlot = 1'b1;
        if (memGnt) begin
          strobe.bumpPtr = 1'b1;
          nextState = S_NEXT;
        end
      end
      S_NEXT: begin
        if (lastLine) nextState = S_IDLE;
        else begin
          strobe.nextLine = 1'b1;
          nextState = S_RD_ASM;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      rxIrq <= 1'b0;
    end else begin
      state <= nextState;
      rxIrq <= strobe.bumpPtr && recvIntEnable;
    end
  end

  assign memReq = (state == S_RD_ASM) || (state == S_WR_ASM) ||
                  (state == S_RD_SLOT) || (state == S_WR_SLOT);
  assign memWe  = (state == S_WR_ASM) || (state == S_WR_SLOT);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memWe)); // R2
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(memReq && memGnt && memWe) && $past(recvIntEnable)); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) && !recvEnable |=> !memReq); // R11
endmodule

// File: rtl/mux_rx_engine.sv
module mux_rx_engine
  import mux_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] rxLines,
  input  logic                 sampleTick,
  input  logic                 recvEnable,
  input  logic                 recvIntEnable,
  input  logic [1:0]           charLen,
  input  logic [BASE_W-1:0]    tableBase,
  input  logic                 ovrClr,
  input  logic                 memGnt,
  input  logic [WORD_W-1:0]    memRdata,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [WORD_W-1:0]    memWdata,
  output logic                 rxIrq,
  output logic                 overrunFlag
);
  ctrlStrobe_t strobe;
  logic charDone, lastLine;

  mux_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .recvEnable(recvEnable),
    .recvIntEnable(recvIntEnable), .memGnt(memGnt), .charDone(charDone),
    .lastLine(lastLine), .slotTaken(memRdata[WORD_W-1]), .strobe(strobe),
    .memReq(memReq), .memWe(memWe), .rxIrq(rxIrq)
  );

  mux_rx_datapath dp_i (
    .clk(clk), .rstN(rstN), .rxLines(rxLines), .tableBase(tableBase),
    .charLen(charLen), .ovrClr(ovrClr), .memRdata(memRdata), .strobe(strobe),
    .memAddr(memAddr), .memWdata(memWdata), .charDone(charDone),
    .lastLine(lastLine), .overrunFlag(overrunFlag)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> $stable(memAddr) && $stable(memWdata)); // R2
  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[ADDR_W-1:7] == tableBase); // R2
  AST_ENTRY_TAGGED: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAddr[6] |-> memWdata[15] && !memWdata[8]); // R6
endmodule

// File: tb/mux_rx_engine_tb_top.sv
module mux_rx_engine_tb_top;
  import mux_rx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 150;
  localparam int WATCHDOG   = 190000;
  localparam logic [7:0] BASE = 8'hA5;
  // row: {frame[1:0], lenCode[1:0], line[3:0], char[7:0]}
  localparam int NROWS = 8;
  localparam logic [15:0] VEC [NROWS] = '{
    {2'd0, 2'd3, 4'd0,  8'h55}, {2'd0, 2'd3, 4'd3,  8'hA3},
    {2'd0, 2'd3, 4'd9,  8'hFF}, {2'd0, 2'd3, 4'd15, 8'h01},
    {2'd1, 2'd0, 4'd2,  8'hEA}, {2'd1, 2'd0, 4'd7,  8'h1F},
    {2'd2, 2'd2, 4'd4,  8'hC5}, {2'd2, 2'd2, 4'd11, 8'h3C}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] rxLines = '1;
  logic sampleTick = 1'b0, recvEnable = 1'b1, recvIntEnable = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic [7:0] tableBase = BASE;
  logic ovrClr = 1'b0;
  logic memGnt, memReq, memWe, rxIrq, overrunFlag;
  logic [15:0] memRdata = '0, memWdata;
  logic [14:0] memAddr;

  mux_rx_engine dut_i (
    .clk(clk), .rstN(rstN), .rxLines(rxLines), .sampleTick(sampleTick),
    .recvEnable(recvEnable), .recvIntEnable(recvIntEnable), .charLen(charLen),
    .tableBase(tableBase), .ovrClr(ovrClr), .memGnt(memGnt), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .rxIrq(rxIrq), .overrunFlag(overrunFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: 128 words of the table region
  logic [15:0] mem [128];
  logic tbWe = 1'b0;
  logic [6:0] tbIdx = '0;
  logic [15:0] tbData = '0;
  logic stallOn = 1'b0;
  int stallCnt = 0, irqCount = 0, reqCount = 0, baseErr = 0;

  assign memGnt = memReq && !(stallOn && (stallCnt % 3 == 0));

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= '0;
    end else if (tbWe) begin
      mem[tbIdx] <= tbData;
    end else if (memReq && memGnt) begin
      if (memWe) mem[memAddr[6:0]] <= memWdata;
      else memRdata <= mem[memAddr[6:0]];
    end
  end

  always @(negedge clk) begin
    stallCnt <= stallCnt + 1;
    if (rxIrq) irqCount <= irqCount + 1;
    if (memReq) reqCount <= reqCount + 1;
    if (memReq && memAddr[14:7] !== tableBase) baseErr <= baseErr + 1;
  end

  int checks = 0, errors = 0;
  int expPtr = 0;
  logic [7:0] fChar [16];
  logic [15:0] fMask = '0, brkMask = '0;
  int probeAt = -1, probeLine = 0;
  logic [15:0] probeExp = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic memPoke(input int idx, input logic [15:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbIdx = 7'(idx); tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  function automatic logic [15:0] mkEntry(input int line, input logic [7:0] ch,
                                          input int len, input bit brk);
    logic [7:0] m;
    m = ch & 8'((1 << len) - 1);
    if (brk) return {1'b1, 1'b1, 1'b0, 4'(line), 1'b0, 8'h00};
    return {1'b1, 1'b0, ^m, 4'(line), 1'b0, m};
  endfunction

  // drives one serial frame on the lines in fMask (break lines in brkMask)
  task automatic runFrame(input int len, input int totalTicks, input int brkTicks);
    for (int t = 0; t < totalTicks; t++) begin
      logic [15:0] lv;
      for (int l = 0; l < 16; l++) begin
        int pos;
        pos = t / 8;
        if (brkMask[l]) lv[l] = (t < brkTicks) ? 1'b0 : 1'b1;
        else if (fMask[l]) begin
          if (pos == 0) lv[l] = 1'b0;
          else if (pos <= len) lv[l] = fChar[l][pos-1];
          else lv[l] = 1'b1;
        end else lv[l] = 1'b1;
      end
      @(negedge clk);
      rxLines = lv; sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
      repeat (TICK_GAP - 2) @(negedge clk);
      if (t + 1 == probeAt)
        check("R3 assembly word mid-frame", {16'h0, mem[32+probeLine]}, {16'h0, probeExp});
    end
  endtask

  task automatic verifyEntries(input int len, input string tag);
    for (int l = 0; l < 16; l++) begin
      if (fMask[l]) begin
        check(tag, {16'h0, mem[64+expPtr]}, {16'h0, mkEntry(l, fChar[l], len, 1'b0)});
        memPoke(64 + expPtr, 16'h0000);
        expPtr = (expPtr + 1) % 64;
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int irq0, req0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 memReq after reset", {31'h0, memReq}, 32'h0);
    check("R1 rxIrq after reset", {31'h0, rxIrq}, 32'h0);
    check("R1 overrunFlag after reset", {31'h0, overrunFlag}, 32'h0);

    // vector table: frames of characters on several lines at once
    for (int f = 0; f < 3; f++) begin
      int n, len;
      n = 0; len = 8; fMask = '0;
      for (int r = 0; r < NROWS; r++) begin
        if (int'(VEC[r][15:14]) == f) begin
          fMask[VEC[r][11:8]] = 1'b1;
          fChar[VEC[r][11:8]] = VEC[r][7:0];
          charLen = VEC[r][13:12];
          len = 5 + int'(VEC[r][13:12]);
          n++;
        end
      end
      recvIntEnable = (f != 1);
      stallOn = (f == 0);
      irq0 = irqCount;
      runFrame(len, (len + 2) * 8 + 4, 0);
      // R4 R5 R6 R7: bit timing, justification, tags, slot order
      verifyEntries(len, "R4 R5 R6 R7 table entry");
      check("R10 irq count per frame", 32'(irqCount - irq0), recvIntEnable ? 32'(n) : 32'h0);
    end
    stallOn = 1'b0;
    recvIntEnable = 1'b1;
    charLen = 2'd3;

    // R8 break on line 5, with a mid-frame probe of its assembly word (R3)
    fMask = '0; brkMask = 16'h0020;
    probeAt = 48; probeLine = 5; probeExp = 16'h8600;
    irq0 = irqCount;
    runFrame(8, 104, 96);
    probeAt = -1;
    check("R8 break entry", {16'h0, mem[64+expPtr]}, {16'h0, mkEntry(5, 8'h00, 8, 1'b1)});
    memPoke(64 + expPtr, 16'h0);
    expPtr = (expPtr + 1) % 64;
    check("R8 single break entry", {16'h0, mem[64+expPtr]}, 32'h0);
    check("R8 one irq for break", 32'(irqCount - irq0), 32'h1);
    check("R3 line 5 re-armed", {28'h0, mem[37][15:12]}, 32'h0);
    brkMask = '0;

    // R11 receiver disabled
    recvEnable = 1'b0;
    fMask = 16'h0002; fChar[1] = 8'h33;
    req0 = reqCount; irq0 = irqCount;
    runFrame(8, 84, 0);
    check("R11 no memory traffic while disabled", 32'(reqCount - req0), 32'h0);
    check("R11 no entry while disabled", {31'h0, mem[64+expPtr][15]}, 32'h0);
    check("R11 no irq while disabled", 32'(irqCount - irq0), 32'h0);
    recvEnable = 1'b1;

    // R9 overrun: every slot occupied
    for (int i = 0; i < 64; i++) memPoke(64 + i, 16'h8000 | 16'(i));
    fMask = 16'h0040; fChar[6] = 8'h42;
    irq0 = irqCount;
    runFrame(8, 84, 0);
    check("R9 overrun flag set", {31'h0, overrunFlag}, 32'h1);
    check("R9 occupied slot untouched", {16'h0, mem[64+expPtr]}, {16'h0, 16'h8000 | 16'(expPtr)});
    check("R9 no irq on overrun", 32'(irqCount - irq0), 32'h0);
    repeat (20) @(negedge clk);
    check("R9 overrun flag sticky", {31'h0, overrunFlag}, 32'h1);
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
    check("R9 overrun flag cleared", {31'h0, overrunFlag}, 32'h0);
    for (int i = 0; i < 64; i++) memPoke(64 + i, 16'h0000);
    irq0 = irqCount;
    runFrame(8, 84, 0);
    verifyEntries(8, "R9 pointer held after overrun");
    check("R10 irq after overrun recovery", 32'(irqCount - irq0), 32'h1);

    // R7 wrap: four full frames on all lines
    for (int f = 0; f < 4; f++) begin
      fMask = 16'hFFFF;
      for (int l = 0; l < 16; l++) fChar[l] = 8'(l * 17 + f * 3 + 1);
      runFrame(8, 84, 0);
      verifyEntries(8, "R7 entry across pointer wrap");
    end
    check("R7 pointer wrapped", 32'(expPtr), 32'd10);
    check("R9 no overrun with freed slots", {31'h0, overrunFlag}, 32'h0);
    check("R2 every address within base", 32'(baseErr), 32'h0);
    finishRun();
  end
endmodule